// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the register side of a nested, vectored interrupt controller. It sits behind a word-addressed bus window and holds, for each of `NUM_IRQ` external interrupts, an enable bit, a pending bit and an 8-bit priority. It also holds byte-wide priorities for twelve system handlers. Software changes the enable and pending bitmaps through separate set and clear word ranges. A trigger word lets software pend an interrupt by number.

The block checks privilege on every access and answers an unprivileged access with a bus error. The one exception is a write to the trigger word, which an unprivileged caller may make when the user-pend configuration input is high. The block also produces two values for the exception logic next to it. The first is the running execution priority, formed from the fault mask, the primary mask and the base-priority value. The second is the highest-priority interrupt that is both pending and enabled. Lower numbers mean more urgent. Exception numbers of external interrupts are the interrupt index plus 16.

Top module: `irq_reg_frontend`

## Requirements
- R1: After reset, every enable, pending and priority value reads as zero, no interrupt is selected (`best_valid` low), and `exec_prio` is 256 when no mask is set.
- R2: A write to word addresses 0x040–0x04F sets, and a write to 0x060–0x06F clears, the enable bit of interrupt 32·(word&0xF)+bit for each written 1 in an enabled byte lane. Reads of either range return the enable bitmap, and bits at or above `NUM_IRQ` read 0.
- R3: Word addresses 0x080–0x08F set, and 0x0A0–0x0AF clear, pending bits under the same rules as R2. Reads of either range return the pending bitmap.
- R4: Word addresses 0x0C0–0x0CF always read 0. Writes there change no state.
- R5: Word addresses 0x100–0x17B hold one priority byte per interrupt, interrupt 4·(word−0x100)+lane in byte lane `lane`. Only enabled lanes are written. Bytes of unimplemented interrupts read 0.
- R6: Word addresses 0x346–0x348 hold twelve handler priority bytes. The byte in lane `l` of word `w` belongs to handler 4·(w−0x345)+l, which gives handlers 4 to 15.
- R7: A full-word (`req_be`=4'hF) write to word 0x3C0 pends interrupt `wdata[8:0]` when that value is below `NUM_IRQ`, and otherwise does nothing. Bits above 8 are ignored.
- R8: An access with `req_user` high returns `rsp_err`=1, read data 0 and no state change. The only exception is a write to word 0x3C0 while `cfg_user_pend` is 1.
- R9: A privileged access never errors. A trigger write with a partial byte enable, or any write to an unmapped word, is silently dropped. Unmapped words and the trigger word read 0.
- R10: `exec_prio` is −1 when `faultmask` is set. Otherwise it is 0 when `primask` is set. Otherwise it is `basepri & (0xFF << (prio_group+1))` when `basepri` is nonzero. Otherwise it is 256.
- R11: `best_exc` and `best_prio` give the pending and enabled interrupt with the lowest priority value, with ties going to the lower index. `best_exc` is the index plus 16. The result reflects each write in the cycle after the write is accepted.
- R12: Every request gets exactly one response, with `rsp_valid` (and `rsp_err`, `rsp_rdata`) registered on the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_user | input | 1 | Access made at unprivileged level |
| req_waddr | input | 10 | Word address within the 4 KiB window |
| req_be | input | 4 | Byte-lane enables |
| req_wdata | input | 32 | Write data |
| cfg_user_pend | input | 1 | Lets unprivileged code write the trigger word |
| faultmask | input | 1 | Fault mask state |
| primask | input | 1 | Primary interrupt mask state |
| basepri | input | 8 | Base-priority value |
| prio_group | input | 3 | Group-priority split point |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | 32 | Read data |
| exec_prio | output | 10 | Running execution priority, signed |
| best_valid | output | 1 | Some interrupt is pending and enabled |
| best_exc | output | 10 | Exception number of the selected interrupt |
| best_prio | output | 8 | Priority of the selected interrupt |

## Verification
The bench targets the second bitmap word, where only eight of the forty interrupts exist. A decoder that ignored `NUM_IRQ` would show phantom bits there. It checks single-lane priority writes, which catch lane mixing and whole-word overwrites. It also drains all pending interrupts one at a time, under both distinct and equal priorities. An arbiter with a reversed comparison or a high-index tie-break would produce a wrong order. Trigger values at and above the interrupt count, with upper data bits set, expose missing range or mask checks. The privilege cases separate a trigger-word exception that is too wide, such as allowing reads or other offsets, from one that is missing.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_EN_SET,
        RG_EN_CLR,
        RG_PD_SET,
        RG_PD_CLR,
        RG_ACT,
        RG_PRIO,
        RG_HPRI,
        RG_TRIG
    } region_e;

    localparam int unsigned EXT_BASE   = 16;
    localparam int unsigned BM_WORDS   = 16;
    localparam int unsigned PRIO_SLOTS = 496;
    localparam int unsigned HP_COUNT   = 12;

    localparam logic [9:0] W_PRIO0 = 10'h100;
    localparam logic [9:0] W_HP0   = 10'h346;
    localparam logic [9:0] W_TRIG  = 10'h3C0;

endpackage

// File: rtl/irqfe_decode.sv
module irqfe_decode
    import irqfe_pkg::*;
(
    input  logic [9:0] waddr,
    input  logic       is_write,
    input  logic       is_user,
    input  logic       user_pend_ok,
    output region_e    region,
    output logic       deny
);

    always_comb begin
        region = RG_NONE;
        if (waddr inside {[10'h040:10'h04F]})      region = RG_EN_SET;
        else if (waddr inside {[10'h060:10'h06F]}) region = RG_EN_CLR;
        else if (waddr inside {[10'h080:10'h08F]}) region = RG_PD_SET;
        else if (waddr inside {[10'h0A0:10'h0AF]}) region = RG_PD_CLR;
        else if (waddr inside {[10'h0C0:10'h0CF]}) region = RG_ACT;
        else if (waddr inside {[10'h100:10'h17B]}) region = RG_PRIO;
        else if (waddr inside {[10'h346:10'h348]}) region = RG_HPRI;
        else if (waddr == W_TRIG)                  region = RG_TRIG;
    end

    // Only a trigger write with the user-pend enable escapes the privilege check
    always_comb begin
        deny = is_user && !(region == RG_TRIG && is_write && user_pend_ok);
    end

endmodule

// File: rtl/irqfe_bank.sv
module irqfe_bank
    import irqfe_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_go,
    input  region_e              region,
    input  logic [9:0]           waddr,
    input  logic [3:0]           be,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic [NUM_IRQ-1:0]   en_vec,
    output logic [NUM_IRQ-1:0]   pend_vec,
    output logic [NUM_IRQ*8-1:0] prio_flat
);

    localparam int unsigned PAD_BITS = BM_WORDS * 32;
    localparam logic [9:0]  NUM_W    = 10'(NUM_IRQ);

    logic [31:0] lane_mask;
    logic [31:0] bit_mask;
    logic [3:0]  bm_word;
    logic [6:0]  prio_word;
    logic [1:0]  hp_word;
    logic        trig_ok;

    assign lane_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    assign bit_mask  = wdata & lane_mask;
    assign bm_word   = waddr[3:0];
    assign prio_word = 7'(waddr - W_PRIO0);
    assign hp_word   = 2'(waddr - W_HP0);
    assign trig_ok   = wr_go && (region == RG_TRIG) && (be == 4'hF) &&
                       ({1'b0, wdata[8:0]} < NUM_W);

    // Per-interrupt state
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
        localparam logic [3:0] WSEL = 4'(gi / 32);
        localparam int         BSEL = gi % 32;
        localparam logic [6:0] PSEL = 7'(gi / 4);
        localparam int         LSEL = gi % 4;

        logic       en_r;
        logic       pend_r;
        logic [7:0] prio_r;
        logic       bm_hit;

        assign bm_hit = wr_go && (bm_word == WSEL) && bit_mask[BSEL];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_r   <= 1'b0;
                pend_r <= 1'b0;
                prio_r <= 8'h00;
            end else begin
                if (bm_hit && region == RG_EN_SET)
                    en_r <= 1'b1;
                else if (bm_hit && region == RG_EN_CLR)
                    en_r <= 1'b0;

                if ((bm_hit && region == RG_PD_SET) ||
                    (trig_ok && wdata[8:0] == 9'(gi)))
                    pend_r <= 1'b1;
                else if (bm_hit && region == RG_PD_CLR)
                    pend_r <= 1'b0;

                if (wr_go && region == RG_PRIO && prio_word == PSEL && be[LSEL])
                    prio_r <= wdata[8*LSEL +: 8];
            end
        end

        assign en_vec[gi]          = en_r;
        assign pend_vec[gi]        = pend_r;
        assign prio_flat[8*gi +: 8] = prio_r;
    end

    // Handler priority bytes, handlers 4..15
    logic [7:0] hp_pad [16];

    for (genvar gk = 0; gk < 16; gk++) begin : g_hp
        if (gk < HP_COUNT) begin : g_impl
            localparam logic [1:0] HSEL = 2'(gk / 4);
            localparam int         HL   = gk % 4;
            logic [7:0] hp_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    hp_r <= 8'h00;
                else if (wr_go && region == RG_HPRI && hp_word == HSEL && be[HL])
                    hp_r <= wdata[8*HL +: 8];
            end
            assign hp_pad[gk] = hp_r;
        end else begin : g_none
            assign hp_pad[gk] = 8'h00;
        end
    end

    // Read-side padding to the full architectural window
    logic [PAD_BITS-1:0] en_pad;
    logic [PAD_BITS-1:0] pend_pad;
    logic [7:0]          prio_pad [PRIO_SLOTS];

    always_comb begin
        en_pad                = '0;
        pend_pad              = '0;
        en_pad[NUM_IRQ-1:0]   = en_vec;
        pend_pad[NUM_IRQ-1:0] = pend_vec;
    end

    for (genvar gp = 0; gp < PRIO_SLOTS; gp++) begin : g_ppad
        if (gp < NUM_IRQ) begin : g_impl
            assign prio_pad[gp] = prio_flat[8*gp +: 8];
        end else begin : g_none
            assign prio_pad[gp] = 8'h00;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (region)
            RG_EN_SET, RG_EN_CLR: rdata = en_pad[{bm_word, 5'd0} +: 32];
            RG_PD_SET, RG_PD_CLR: rdata = pend_pad[{bm_word, 5'd0} +: 32];
            RG_PRIO: begin
                for (int l = 0; l < 4; l++)
                    rdata[8*l +: 8] = prio_pad[{prio_word, 2'(l)}];
            end
            RG_HPRI: begin
                for (int l = 0; l < 4; l++)
                    rdata[8*l +: 8] = hp_pad[{hp_word, 2'(l)}];
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqfe_arbiter.sv
module irqfe_arbiter #(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]   en_vec,
    input  logic [NUM_IRQ-1:0]   pend_vec,
    input  logic [NUM_IRQ*8-1:0] prio_flat,
    output logic                 found,
    output logic [9:0]           exc_num,
    output logic [7:0]           exc_prio
);

    localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [IDX_W-1:0] win;
    logic [7:0]       win_prio;

    // Ascending scan with strict compare: equal priorities keep the lower index
    always_comb begin
        found    = 1'b0;
        win      = '0;
        win_prio = 8'hFF;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (en_vec[i] && pend_vec[i] &&
                (!found || prio_flat[8*i +: 8] < win_prio)) begin
                found    = 1'b1;
                win      = IDX_W'(i);
                win_prio = prio_flat[8*i +: 8];
            end
        end
    end

    assign exc_num  = found ? (10'(win) + 10'd16) : 10'd0;
    assign exc_prio = found ? win_prio : 8'h00;

endmodule

// File: rtl/irqfe_execprio.sv
module irqfe_execprio (
    input  logic              faultmask,
    input  logic              primask,
    input  logic [7:0]        basepri,
    input  logic [2:0]        prio_group,
    output logic signed [9:0] exec_prio
);

    logic [3:0] shamt;
    logic [7:0] gmask;

    assign shamt = {1'b0, prio_group} + 4'd1;
    assign gmask = 8'hFF << shamt;

    always_comb begin
        if (faultmask)
            exec_prio = -10'sd1;
        else if (primask)
            exec_prio = 10'sd0;
        else if (basepri != 8'h00)
            exec_prio = $signed({2'b00, basepri & gmask});
        else
            exec_prio = 10'sd256;
    end

endmodule

// File: rtl/irq_reg_frontend.sv
module irq_reg_frontend
    import irqfe_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [9:0]        req_waddr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    input  logic              cfg_user_pend,
    input  logic              faultmask,
    input  logic              primask,
    input  logic [7:0]        basepri,
    input  logic [2:0]        prio_group,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic signed [9:0] exec_prio,
    output logic              best_valid,
    output logic [9:0]        best_exc,
    output logic [7:0]        best_prio
);

    region_e              region;
    logic                 deny;
    logic                 wr_go;
    logic [31:0]          rd_word;
    logic [NUM_IRQ-1:0]   en_vec;
    logic [NUM_IRQ-1:0]   pend_vec;
    logic [NUM_IRQ*8-1:0] prio_flat;

    irqfe_decode i_decode (
        .waddr        (req_waddr),
        .is_write     (req_write),
        .is_user      (req_user),
        .user_pend_ok (cfg_user_pend),
        .region       (region),
        .deny         (deny)
    );

    assign wr_go = req_valid && req_write && !deny;

    irqfe_bank #(.NUM_IRQ(NUM_IRQ)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .region    (region),
        .waddr     (req_waddr),
        .be        (req_be),
        .wdata     (req_wdata),
        .rdata     (rd_word),
        .en_vec    (en_vec),
        .pend_vec  (pend_vec),
        .prio_flat (prio_flat)
    );

    irqfe_arbiter #(.NUM_IRQ(NUM_IRQ)) i_arb (
        .en_vec    (en_vec),
        .pend_vec  (pend_vec),
        .prio_flat (prio_flat),
        .found     (best_valid),
        .exc_num   (best_exc),
        .exc_prio  (best_prio)
    );

    irqfe_execprio i_exec (
        .faultmask  (faultmask),
        .primask    (primask),
        .basepri    (basepri),
        .prio_group (prio_group),
        .exec_prio  (exec_prio)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && deny;
            rsp_rdata <= (req_valid && !req_write && !deny) ? rd_word : 32'h0;
        end
    end

endmodule

// File: rtl/irq_reg_frontend_chk.sv
module irq_reg_frontend_chk #(
    parameter int unsigned NUM_IRQ = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_user,
    input logic [9:0]        req_waddr,
    input logic              cfg_user_pend,
    input logic              faultmask,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic signed [9:0] exec_prio,
    input logic              best_valid,
    input logic [9:0]        best_exc
);

    localparam logic [9:0] EXC_LO = 10'd16;
    localparam logic [9:0] EXC_HI = 10'(NUM_IRQ + 16);

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R12
    AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R12
    AST_ERR_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid); // R12
    AST_USER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_user &&
         !(req_write && cfg_user_pend && req_waddr == 10'h3C0)) |=> rsp_err); // R8
    AST_PRIV_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_user) |=> !rsp_err); // R9
    AST_FAULT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        faultmask |-> exec_prio == -10'sd1); // R10
    AST_BEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |-> (best_exc >= EXC_LO && best_exc < EXC_HI)); // R11

endmodule

bind irq_reg_frontend irq_reg_frontend_chk #(.NUM_IRQ(NUM_IRQ)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_user      (req_user),
    .req_waddr     (req_waddr),
    .cfg_user_pend (cfg_user_pend),
    .faultmask     (faultmask),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .exec_prio     (exec_prio),
    .best_valid    (best_valid),
    .best_exc      (best_exc)
);

// File: tb/test_irq_reg_frontend.sv
`timescale 1ns/1ps
module test_irq_reg_frontend;

    localparam int N = 40;
    localparam logic [63:0] IMPL = (64'd1 << N) - 64'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [9:0]        req_waddr = '0;
    logic [3:0]        req_be = '0;
    logic [31:0]       req_wdata = '0;
    logic              cfg_user_pend = 1'b0, faultmask = 1'b0, primask = 1'b0;
    logic [7:0]        basepri = '0;
    logic [2:0]        prio_group = '0;
    logic              rsp_valid, rsp_err, best_valid;
    logic [31:0]       rsp_rdata;
    logic signed [9:0] exec_prio;
    logic [9:0]        best_exc;
    logic [7:0]        best_prio;

    int nchk = 0, nfail = 0;
    bit done = 0;

    logic [63:0] m_en = '0, m_pd = '0;
    logic [7:0]  m_pr [N];
    logic [7:0]  m_hp [12];

    always #10 clk = ~clk;

    irq_reg_frontend #(.NUM_IRQ(N)) i_irq_reg_frontend (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic u, input logic [9:0] a, input logic [3:0] be,
                       input logic [31:0] d, output logic [31:0] rd, output logic er);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_user = u;
        req_waddr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_user = 1'b0;
        chk("R12 rsp_valid", 32'(rsp_valid), 32'd1);
        rd = rsp_rdata; er = rsp_err;
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] rd; logic er;
        bus(1'b1, 1'b0, a, be, d, rd, er);
    endtask

    task automatic rdw(input logic [9:0] a, output logic [31:0] rd);
        logic er;
        bus(1'b0, 1'b0, a, 4'hF, 32'h0, rd, er);
    endtask

    task automatic chk_bitmap(input string tag, input logic [9:0] base, input logic [63:0] m);
        logic [31:0] rd;
        for (int w = 0; w < 2; w++) begin
            rdw(base + 10'(w), rd);
            chk(tag, rd, m[32*w +: 32]);
        end
    endtask

    function automatic logic [7:0] fpri(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    task automatic chk_best(input string tag, output logic v, output int idx);
        logic [7:0] p;
        v = 1'b0; idx = 0; p = 8'h00;
        for (int i = 0; i < N; i++)
            if (m_en[i] && m_pd[i] && (!v || m_pr[i] < p)) begin
                v = 1'b1; idx = i; p = m_pr[i];
            end
        chk(tag, 32'(best_valid), 32'(v));
        if (v) begin
            chk(tag, 32'(best_exc), 32'(idx + 16));
            chk(tag, 32'(best_prio), 32'(p));
        end
    endtask

    task automatic drain(input string tag);
        logic v; int idx;
        for (int n = 0; n <= N; n++) begin
            chk_best(tag, v, idx);
            if (!v) break;
            wr(10'h0A0 + 10'(idx / 32), 4'hF, 32'd1 << (idx % 32));
            m_pd[idx] = 1'b0;
        end
    endtask

    function automatic int exp_exec(input logic fm, input logic pm, input logic [7:0] bp,
                                    input logic [2:0] g);
        if (fm) return -1;
        if (pm) return 0;
        if (bp != 0) return int'(bp & (8'hFF << (int'(g) + 1)));
        return 256;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, d, q; logic er; logic v; int idx;
        logic [31:0] pats [3];
        logic [7:0]  bps [5];
        pats[0] = 32'hA5A5_0F0F; pats[1] = 32'h1234_5678; pats[2] = 32'hFFFF_FFFF;
        bps[0] = 8'h00; bps[1] = 8'h01; bps[2] = 8'h80; bps[3] = 8'hFF; bps[4] = 8'h37;
        for (int i = 0; i < N; i++) m_pr[i] = 8'h00;
        for (int k = 0; k < 12; k++) m_hp[k] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 best_valid", 32'(best_valid), 32'd0);
        chk("R1 exec_prio", 32'($signed(exec_prio)), 32'd256);
        chk_bitmap("R1 enable", 10'h040, 64'd0);
        chk_bitmap("R1 pending", 10'h080, 64'd0);
        rdw(10'h100, rd); chk("R1 prio", rd, 32'd0);
        rdw(10'h346, rd); chk("R1 handler prio", rd, 32'd0);

        // R2 enable set/clear sweep
        for (int p = 0; p < 3; p++) begin
            wr(10'h040, 4'hF, pats[p]); wr(10'h041, 4'hF, ~pats[p]);
            m_en = m_en | ({~pats[p], pats[p]} & IMPL);
            q = pats[p] ^ 32'h0FF0_0FF0;
            wr(10'h060, 4'hF, q); wr(10'h061, 4'hF, q);
            m_en = m_en & ~{q, q};
            chk_bitmap("R2 set-range read", 10'h040, m_en);
            chk_bitmap("R2 clr-range read", 10'h060, m_en);
        end
        wr(10'h060, 4'hF, '1); wr(10'h061, 4'hF, '1); m_en = '0;
        wr(10'h040, 4'b0010, 32'hFFFF_FFFF); m_en = 64'h0000_FF00;
        chk_bitmap("R2 lane write", 10'h040, m_en);
        wr(10'h04F, 4'hF, '1);
        chk_bitmap("R2 unimplemented word", 10'h040, m_en);

        // R3 pending set/clear sweep
        for (int p = 0; p < 3; p++) begin
            wr(10'h080, 4'hF, ~pats[p]); wr(10'h081, 4'hF, pats[p]);
            m_pd = m_pd | ({pats[p], ~pats[p]} & IMPL);
            q = pats[p] ^ 32'h3C3C_3C3C;
            wr(10'h0A0, 4'hF, q); wr(10'h0A1, 4'hF, q);
            m_pd = m_pd & ~{q, q};
            chk_bitmap("R3 set-range read", 10'h080, m_pd);
            chk_bitmap("R3 clr-range read", 10'h0A0, m_pd);
        end

        // R4 active range read-only
        wr(10'h0C0, 4'hF, '1); wr(10'h0C1, 4'hF, '1);
        rdw(10'h0C0, rd); chk("R4 active", rd, 32'd0);
        rdw(10'h0C1, rd); chk("R4 active", rd, 32'd0);
        chk_bitmap("R4 pending untouched", 10'h080, m_pd);
        chk_bitmap("R4 enable untouched", 10'h040, m_en);

        // R5 priority bytes, one lane at a time
        for (int i = 0; i < N; i++) begin
            d = 32'h5A5A_5A5A; d[8*(i%4) +: 8] = fpri(i);
            wr(10'h100 + 10'(i / 4), 4'd1 << (i % 4), d);
            m_pr[i] = fpri(i);
        end
        wr(10'h10A, 4'hF, '1);
        for (int w = 0; w < 11; w++) begin
            d = '0;
            for (int l = 0; l < 4; l++)
                if (4*w + l < N) d[8*l +: 8] = m_pr[4*w + l];
            rdw(10'h100 + 10'(w), rd); chk("R5 prio word", rd, d);
        end
        rdw(10'h17B, rd); chk("R5 last word", rd, 32'd0);

        // R6 handler priorities
        for (int k = 0; k < 12; k++) begin
            m_hp[k] = 8'(8'h11 + k * 19);
            wr(10'h346 + 10'(k / 4), 4'd1 << (k % 4), {4{m_hp[k]}});
        end
        for (int w = 0; w < 3; w++) begin
            rdw(10'h346 + 10'(w), rd);
            chk("R6 handler word", rd, {m_hp[4*w+3], m_hp[4*w+2], m_hp[4*w+1], m_hp[4*w]});
        end

        // R11 arbitration: distinct priorities, then ties, then enable masking
        wr(10'h040, 4'hF, '1); wr(10'h041, 4'hF, '1); m_en = IMPL;
        wr(10'h080, 4'hF, '1); wr(10'h081, 4'hF, '1); m_pd = IMPL;
        drain("R11 distinct");
        for (int w = 0; w < 10; w++) wr(10'h100 + 10'(w), 4'hF, 32'h4040_4040);
        for (int i = 0; i < N; i++) m_pr[i] = 8'h40;
        wr(10'h100, 4'b0100, 32'h0030_0000); m_pr[2] = 8'h30;
        wr(10'h060, 4'hF, 32'h0000_0F04); m_en = m_en & ~64'h0F04;
        wr(10'h080, 4'hF, 32'h00F0_F0FF); wr(10'h081, 4'hF, 32'h81); m_pd = 64'h81_00F0_F0FF;
        drain("R11 ties");

        // R7 trigger word sweep
        for (int v7 = 0; v7 < 48; v7++) begin
            wr(10'h0A0, 4'hF, '1); wr(10'h0A1, 4'hF, '1); m_pd = '0;
            wr(10'h3C0, 4'hF, 32'(v7) | 32'hFFFF_FE00);
            if (v7 < N) m_pd[v7] = 1'b1;
            chk_bitmap("R7 trigger", 10'h080, m_pd);
        end
        wr(10'h0A0, 4'hF, '1); wr(10'h0A1, 4'hF, '1); m_pd = '0;
        wr(10'h3C0, 4'hF, 32'h0000_0205); m_pd[5] = 1'b1;
        chk_bitmap("R7 upper bits masked", 10'h080, m_pd);
        chk_best("R7 best after trigger", v, idx);

        // R9 silent drops
        bus(1'b1, 1'b0, 10'h3C0, 4'h3, 32'd9, rd, er);
        chk("R9 partial trigger no err", 32'(er), 32'd0);
        chk_bitmap("R9 partial trigger ignored", 10'h080, m_pd);
        bus(1'b1, 1'b0, 10'h1C0, 4'hF, '1, rd, er);
        chk("R9 unmapped write no err", 32'(er), 32'd0);
        bus(1'b0, 1'b0, 10'h1C0, 4'hF, '0, rd, er);
        chk("R9 unmapped read", rd, 32'd0);
        chk("R9 unmapped read no err", 32'(er), 32'd0);
        rdw(10'h3C0, rd); chk("R9 trigger read", rd, 32'd0);

        // R8 privilege
        bus(1'b0, 1'b1, 10'h040, 4'hF, '0, rd, er);
        chk("R8 user read err", 32'(er), 32'd1);
        chk("R8 user read data", rd, 32'd0);
        bus(1'b1, 1'b1, 10'h060, 4'hF, '1, rd, er);
        chk("R8 user write err", 32'(er), 32'd1);
        chk_bitmap("R8 user write ignored", 10'h040, m_en);
        bus(1'b1, 1'b1, 10'h3C0, 4'hF, 32'd7, rd, er);
        chk("R8 user trigger denied", 32'(er), 32'd1);
        chk_bitmap("R8 user trigger no effect", 10'h080, m_pd);
        cfg_user_pend = 1'b1;
        bus(1'b1, 1'b1, 10'h3C0, 4'hF, 32'd7, rd, er); m_pd[7] = 1'b1;
        chk("R8 user trigger allowed", 32'(er), 32'd0);
        chk_bitmap("R8 user trigger pends", 10'h080, m_pd);
        bus(1'b0, 1'b1, 10'h3C0, 4'hF, '0, rd, er);
        chk("R8 user trigger read err", 32'(er), 32'd1);
        bus(1'b1, 1'b1, 10'h080, 4'hF, '1, rd, er);
        chk("R8 user pend write err", 32'(er), 32'd1);
        chk_bitmap("R8 user pend write ignored", 10'h080, m_pd);
        cfg_user_pend = 1'b0;

        // R10 execution priority sweep
        for (int fm = 0; fm < 2; fm++)
            for (int pm = 0; pm < 2; pm++)
                for (int b = 0; b < 5; b++)
                    for (int g = 0; g < 8; g++) begin
                        @(negedge clk);
                        faultmask = fm[0]; primask = pm[0];
                        basepri = bps[b]; prio_group = 3'(g);
                        #1;
                        chk("R10 exec_prio", 32'($signed(exec_prio)),
                            32'(exp_exec(fm[0], pm[0], bps[b], 3'(g))));
                    end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule